// File: doc/BRIEF.md
# Subblocked Write-Through Data Cache

This block is a direct-mapped data cache that sits between a processor's word-wide load/store port and a single-word memory port. Each line is divided into one-word subblocks, and every subblock has its own valid bit. A read that misses fetches only the word it asked for. The whole line is never filled.

Writes never wait for a fetch. The addressed word is written into the cache at once. If the line's tag differs from the write's tag, the line is taken over by that write: its tag is replaced, the written word is marked valid, and every other word of the line is marked invalid. Every write is also passed through to memory. Because memory always holds the current data, claiming a line this way never loses anything.

The processor holds a request until the block raises its ready signal. A read hit completes in the cycle it is presented. A read miss completes in the cycle memory acknowledges, with the fetched word passed straight to the processor. A write completes in the cycle memory acknowledges the write-through.

Top module: `swt_cache`

## Requirements
- R1: After reset every subblock of every line is invalid, so the first read of any address is a miss, even one whose tag field is zero.
- R2: A read whose tag equals the line's tag and whose subblock is valid raises `cpu_ready` in the cycle it is presented, returns the cached word on `cpu_rdata`, and starts no memory access.
- R3: A read miss issues exactly one memory read, of the addressed word. It completes with `cpu_ready` high and `cpu_rdata` equal to `mem_rdata` in the cycle `mem_ack` is high. That word is valid afterwards.
- R4: A read miss whose tag differs from the line's tag replaces the line's tag and invalidates all other subblocks of that line. A read miss whose tag matches leaves the other subblocks as they were.
- R5: A write whose tag matches and whose subblock is valid replaces the cached word, and the word stays valid.
- R6: A write whose tag matches and whose subblock is invalid stores the word and makes that subblock valid, so a later read of it hits.
- R7: A write whose tag differs from the line's tag replaces the tag, makes only the written subblock valid, and invalidates all other subblocks of the line, with no memory read.
- R8: Every write, hit or miss, raises `mem_req` with `mem_we` high, the write's address and the write's data in the cycle after it is presented. The write completes with `cpu_ready` in the cycle `mem_ack` is high.
- R9: `cpu_ready` is low while a memory request is outstanding and not yet acknowledged, and low when no request is presented. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R10: `cpu_addr` is a word address. Its low `OFF_W` bits (default 2) select the subblock, the next `IDX_W` bits (default 3) select the line, and the remaining upper bits are the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_req | output | 1 | Memory access requested, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word address sent to memory |
| mem_wdata | output | DATA_W | Data sent to memory on writes |
| mem_rdata | input | DATA_W | Data returned by memory, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current access |

## Verification
Directed sequences walk one line through each tag and valid case in turn:
- a cold miss on tag zero, which separates a cleared valid bit from a reset tag value;
- a sibling miss under a matching tag, which shows that only one word is filled;
- writes to valid and to invalid words, which separate R5 from R6;
- a retagging write followed by reads of the old tag and of sibling words, which shows that the siblings were invalidated without a fetch.

A second phase issues a pseudo-random mix of reads and writes over a few tags and lines, with memory latencies from one to four cycles. This mix catches wrong field slicing, stale data after a retag, and ready or handshake timing that only goes wrong at particular latencies.

// File: rtl/swt_pkg.sv
// Package: shared types for the subblocked write-through cache.
// Assumes one outstanding memory access at a time.
package swt_pkg;

    // Controller phase: waiting for a request, fetching a word, or writing through.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WTHRU = 2'd2
    } swt_state_t;

endpackage

// File: rtl/swt_tag_store.sv
// Tag and per-subblock valid storage for a direct-mapped cache.
// Lookup is combinational. An update either sets one valid bit (tag match)
// or retags the line and keeps only the updated subblock valid (mismatch).
// Assumes at most one update per cycle. Reset clears all valid bits and tags.
module swt_tag_store #(
    parameter int IDX_W = 3,
    parameter int OFF_W = 2,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [OFF_W-1:0] lk_off,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_tag_eq,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [OFF_W-1:0] upd_off,
    input  logic [TAG_W-1:0] upd_tag
);
    localparam int LINES = 1 << IDX_W;
    localparam int SUBS  = 1 << OFF_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [SUBS-1:0]  vld_q [LINES];
    logic [SUBS-1:0]  upd_sel;

    // Decode the updated subblock into a one-hot mask.
    always_comb upd_sel = {{(SUBS-1){1'b0}}, 1'b1} << upd_off;

    // Lookup: tag compare and valid bit of the addressed subblock.
    always_comb begin
        lk_tag_eq = (tag_q[lk_idx] == lk_tag);
        lk_hit    = lk_tag_eq && vld_q[lk_idx][lk_off];
    end

    for (genvar l = 0; l < LINES; l++) begin : g_line
        // Per-line update following the tag-match / tag-mismatch rules.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[l] <= '0;
                vld_q[l] <= '0;
            end else if (upd_en && (upd_idx == IDX_W'(l))) begin
                if (tag_q[l] != upd_tag) begin
                    tag_q[l] <= upd_tag;
                    vld_q[l] <= upd_sel;
                end else begin
                    vld_q[l] <= vld_q[l] | upd_sel;
                end
            end
        end
    end
endmodule

// File: rtl/swt_data_store.sv
// Word storage for all subblocks: one synchronous write port and one
// combinational read port. Contents are not reset; the valid bits guard them.
module swt_data_store #(
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [IDX_W+OFF_W-1:0] wr_slot,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [IDX_W+OFF_W-1:0] rd_slot,
    output logic [DATA_W-1:0]      rd_data
);
    localparam int SLOTS = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] word_q [SLOTS];

    // Store the written word.
    always_ff @(posedge clk) begin
        if (wr_en) word_q[wr_slot] <= wr_data;
    end

    // Read the addressed word.
    always_comb rd_data = word_q[rd_slot];
endmodule

// File: rtl/swt_ctrl.sv
// Request sequencer. It answers read hits at once, fetches one word on a
// read miss, and writes every store into the cache on acceptance before
// passing it to memory. Assumes the processor holds its request until
// cpu_ready, and that memory keeps mem_ack low except to complete a request.
module swt_ctrl
    import swt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              fwd_mem,
    input  logic              lk_hit,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_addr,
    output logic [DATA_W-1:0] upd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    swt_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              latch;

    // Next-state and output decode for the three phases.
    always_comb begin
        state_d   = state_q;
        cpu_ready = 1'b0;
        fwd_mem   = 1'b0;
        upd_en    = 1'b0;
        upd_addr  = cpu_addr;
        upd_data  = cpu_wdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        latch     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        upd_en  = 1'b1;
                        latch   = 1'b1;
                        state_d = ST_WTHRU;
                    end else if (lk_hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        latch   = 1'b1;
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                upd_addr = addr_q;
                upd_data = mem_rdata;
                if (mem_ack) begin
                    upd_en    = 1'b1;
                    cpu_ready = 1'b1;
                    fwd_mem   = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_WTHRU: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Memory port carries the latched request.
    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request that leaves the idle phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (latch) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
        end
    end
endmodule

// File: rtl/swt_cache.sv
// Top of the subblocked write-through cache: splits word addresses into
// tag, line index and subblock offset, and wires the sequencer to the tag
// and word stores. Read data comes from the store on a hit and straight
// from memory on the fill cycle.
module swt_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int SLOT_W = IDX_W + OFF_W;
    localparam int TAG_W  = ADDR_W - SLOT_W;

    logic              lk_hit, lk_tag_eq, upd_en, fwd_mem;
    logic [ADDR_W-1:0] upd_addr;
    logic [DATA_W-1:0] upd_data, store_rdata;

    swt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .fwd_mem(fwd_mem),
        .lk_hit(lk_hit), .upd_en(upd_en), .upd_addr(upd_addr),
        .upd_data(upd_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    swt_tag_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(cpu_addr[SLOT_W-1:OFF_W]), .lk_off(cpu_addr[OFF_W-1:0]),
        .lk_tag(cpu_addr[ADDR_W-1:SLOT_W]),
        .lk_hit(lk_hit), .lk_tag_eq(lk_tag_eq),
        .upd_en(upd_en),
        .upd_idx(upd_addr[SLOT_W-1:OFF_W]), .upd_off(upd_addr[OFF_W-1:0]),
        .upd_tag(upd_addr[ADDR_W-1:SLOT_W])
    );

    swt_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_words (
        .clk(clk), .wr_en(upd_en), .wr_slot(upd_addr[SLOT_W-1:0]),
        .wr_data(upd_data), .rd_slot(cpu_addr[SLOT_W-1:0]),
        .rd_data(store_rdata)
    );

    // Pick forwarded memory data on the fill cycle, stored word otherwise.
    always_comb cpu_rdata = fwd_mem ? mem_rdata : store_rdata;
endmodule

// File: rtl/swt_cache_chk.sv
// Port-level protocol checks for swt_cache, attached with bind.
module swt_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_ack
);
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> !cpu_ready);

    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_write_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !mem_req) |=>
        (mem_req && mem_we && mem_addr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata)));

    p_write_not_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !mem_req) |-> !cpu_ready);

    p_fill_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |-> (cpu_ready && cpu_rdata == mem_rdata));

    p_miss_one_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_ready && !mem_req) |=>
        (mem_req && !mem_we && mem_addr == $past(cpu_addr)));

    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready && !mem_req) |=> !mem_req);
endmodule

bind swt_cache swt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
);

// File: tb/swt_cache_bench.sv
// Bench for swt_cache: a behavioural cache and memory model predicts the
// outputs of every cycle of every request and compares them.
module swt_cache_bench;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int LINES  = 8;
    localparam int SUBS   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cpu_req, cpu_we, cpu_ready, mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] cpu_addr, mem_addr;
    logic [DATA_W-1:0] cpu_wdata, cpu_rdata, mem_wdata, mem_rdata;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    int          m_tag  [LINES];
    bit          m_vld  [LINES][SUBS];
    logic [31:0] m_data [LINES][SUBS];
    logic [31:0] m_mem  [int];

    always #5 clk = ~clk;

    swt_cache u_swt_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [31:0] mem_val(input int a);
        if (m_mem.exists(a)) return m_mem[a];
        return (32'(a) * 32'h9E37_79B1) ^ 32'h00C0_FFEE;
    endfunction

    function automatic logic [11:0] mk(input int tg, input int ix, input int of);
        return 12'((tg << 5) | (ix << 2) | of);
    endfunction

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One processor request with memory answering after lat cycles (R10 field split).
    task automatic op(input bit we, input logic [11:0] a, input logic [31:0] wd,
                      input int lat, input string rq);
        int  ix = int'(a[4:2]);
        int  of = int'(a[1:0]);
        int  tg = int'(a[11:5]);
        bit  hit = !we && (m_tag[ix] == tg) && m_vld[ix][of];
        int  l = (lat < 1) ? 1 : lat;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        for (int c = 0; c < 60; c++) begin
            mem_ack   = (c == l);
            mem_rdata = (mem_ack && !we) ? mem_val(int'(a)) : 32'h0;
            #4;
            if (hit) begin
                chk({rq, " R2"}, "hit ready", 32'(cpu_ready), 32'd1);
                chk({rq, " R2"}, "hit data", cpu_rdata, m_data[ix][of]);
                chk({rq, " R2"}, "hit mem_req", 32'(mem_req), 32'd0);
                break;
            end
            if (c == 0) begin
                chk({rq, " R9"}, "accept ready", 32'(cpu_ready), 32'd0);
                chk({rq, " R9"}, "accept mem_req", 32'(mem_req), 32'd0);
            end else begin
                chk({rq, " R8 R3"}, "mem_req", 32'(mem_req), 32'd1);
                chk({rq, " R8 R3"}, "mem_we", 32'(mem_we), 32'(we));
                chk({rq, " R10"}, "mem_addr", 32'(mem_addr), 32'(a));
                if (we) chk({rq, " R8"}, "mem_wdata", mem_wdata, wd);
                chk({rq, " R9"}, "ready vs ack", 32'(cpu_ready), 32'(mem_ack));
                if (mem_ack) begin
                    if (!we) chk({rq, " R3"}, "fill data", cpu_rdata, mem_val(int'(a)));
                    break;
                end
            end
            @(negedge clk);
        end
        @(negedge clk);
        cpu_req = 1'b0; mem_ack = 1'b0; mem_rdata = 32'h0;
        if (!hit) begin
            if (m_tag[ix] != tg) begin
                m_tag[ix] = tg;
                for (int s = 0; s < SUBS; s++) m_vld[ix][s] = 1'b0;
            end
            m_vld[ix][of] = 1'b1;
            if (we) begin
                m_data[ix][of]  = wd;
                m_mem[int'(a)] = wd;
            end else begin
                m_data[ix][of] = mem_val(int'(a));
            end
        end
        #4;
        chk({rq, " R9"}, "idle ready", 32'(cpu_ready), 32'd0);
        chk({rq, " R9"}, "idle mem_req", 32'(mem_req), 32'd0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R9 actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned s = 32'd12345;
        for (int l = 0; l < LINES; l++) begin
            m_tag[l] = 0;
            for (int k = 0; k < SUBS; k++) begin
                m_vld[l][k] = 1'b0;
                m_data[l][k] = 32'h0;
            end
        end
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
        cpu_wdata = '0; mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        #4;
        chk("R1", "reset ready", 32'(cpu_ready), 32'd0);
        chk("R1", "reset mem_req", 32'(mem_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        op(0, mk(0, 0, 0), 0, 3, "R1 cold miss tag zero");
        op(0, mk(0, 0, 0), 0, 1, "R2 rehit");
        op(0, mk(0, 0, 1), 0, 1, "R3 sibling miss");
        op(0, mk(0, 0, 0), 0, 1, "R4 sibling kept on match");
        op(1, mk(0, 0, 1), 32'hAAAA_0001, 2, "R5 write valid");
        op(0, mk(0, 0, 1), 0, 1, "R5 readback");
        op(1, mk(0, 0, 2), 32'hBBBB_0002, 1, "R6 write invalid");
        op(0, mk(0, 0, 2), 0, 1, "R6 readback");
        op(1, mk(5, 0, 3), 32'hCCCC_0003, 4, "R7 retag write");
        op(0, mk(5, 0, 3), 0, 1, "R7 retag hit");
        op(0, mk(5, 0, 0), 0, 2, "R7 sibling invalid");
        op(0, mk(0, 0, 1), 0, 2, "R4 read retag");
        op(0, mk(5, 0, 0), 0, 1, "R4 sibling cleared");
        op(0, mk(0, 0, 1), 0, 1, "R8 old write reached memory");
        op(1, mk(127, 7, 3), 32'hDDDD_0004, 1, "R10 top line");
        op(0, mk(127, 7, 3), 0, 1, "R10 top readback");

        for (int n = 0; n < 80; n++) begin
            bit          w;
            logic [11:0] a;
            s = s * 32'd1103515245 + 32'd12345;
            w = s[20];
            a = mk(int'(s[17:16]) * 9, int'(s[25:24]) * 2 + 1, int'(s[29:28]));
            op(w, a, s ^ 32'h1357_9BDF, int'(s[9:8]) + 1, "R3 R5 R6 R7 mix");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule